// File: doc/BRIEF.md
# Parallel Programming Strobe Sequencer

This block runs the pin sequences that a target device expects in its high-voltage parallel programming mode. It supports four operations: chip erase, fuse write, lock write and a combined fuse/lock read. It drives a 2-bit mode-select pair, a byte-select line derived from that pair, a positive clock strobe, an active-low write enable, an active-low output enable, and an 8-bit data bus with a separate drive-enable.

To load a byte into the target, the block places a mode code on the select pair and the byte on the bus, lets the slow select line settle, then pulses the strobe. The target gives no ready/busy feedback, so every write ends with a fixed completion wait. A read loads its command, returns the select pair to the all-high state, and holds output enable low long enough for the target's bus to settle. It then samples the bus.

A requester presents an operation code and a write byte with a `start` pulse. It receives a one-cycle `done` pulse, and after a read the captured byte. The strobe width, the settle time and the write wait are parameters counted in clock cycles.

Top module: `pps_seq`

## Requirements
- R1: After reset and between operations the pins rest idle: mode select 11, strobe low, write enable high, output enable high, bus not driven with bus value 00, done low, and read byte 00 until the first read.
- R2: Each operation first drives mode select 10 with the bus driven to its command code. With the operation encoding 00 erase, 01 fuse write, 10 lock write, 11 read, the codes are 80, 40, 20 and 04 (hex). This state is held for SETTLE cycles, and then the strobe goes high for PULSE cycles.
- R3: A fuse or lock write follows the command strobe with mode select 01 and the bus driven to the write byte latched at start. It holds SETTLE cycles, then strobes high for PULSE cycles.
- R4: The strobe rises only after the select pair has held its value for at least SETTLE cycles. The select pair and the bus stay unchanged while the strobe is high.
- R5: After the last strobe of a write, the select pair returns to 11 and the bus is released. Write enable is low for PULSE cycles, then all pins rest idle for WAIT cycles before done.
- R6: A read follows its command strobe with select 11 and the bus released for SETTLE cycles. Output enable is then low for SETTLE cycles, and the bus input is captured on the last of them and presented on the read byte.
- R7: Output enable and write enable are never low at the same time.
- R8: Byte-select equals the AND of both mode-select bits, so it is high only in the 11 state.
- R9: A start request that arrives while an operation is in progress, including its done cycle, is ignored and does not alter the running sequence.
- R10: Done is a single-cycle pulse after each operation. The read byte keeps its value until the next read completes.
- R11: Chip erase has no data phase: its command strobe is followed directly by the write-enable pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin an operation |
| op_i | input | 2 | Operation code (00 erase, 01 fuse write, 10 lock write, 11 read) |
| wdata_i | input | 8 | Byte for fuse or lock write |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Byte captured by the last read |
| msel_o | output | 2 | Mode-select pair to the target |
| byte_sel_o | output | 1 | Byte-select, AND of the mode-select pair |
| strobe_o | output | 1 | Positive load strobe |
| we_n_o | output | 1 | Active-low write enable |
| oe_n_o | output | 1 | Active-low output enable |
| bus_drv_o | output | 1 | High while the block drives the data bus |
| bus_o | output | 8 | Data bus value driven to the target |
| bus_i | input | 8 | Data bus value returned by the target |

## Verification
A wrong sequencer state appears at the pins in the same cycle it is entered, because every pin is a register decoded from the next state. Examples are a select code that does not match its phase, a strobe that comes too early, or overlapping enables. A phase timer that is off by one stretches or shortens a phase, and this shows as a pin edge one cycle away from the expected one. A miss on the capture edge shows at the read byte on the done cycle. Since the reference expects exact values on every clock, each such fault is reported within the cycle where it first shows.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int PPS_DW = 8;

  typedef enum logic [1:0] {
    OP_ERASE = 2'b00,
    OP_FUSE  = 2'b01,
    OP_LOCK  = 2'b10,
    OP_READ  = 2'b11
  } pps_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD_SET,
    ST_CMD_STB,
    ST_DAT_SET,
    ST_DAT_STB,
    ST_WE,
    ST_WAIT,
    ST_RD_SET,
    ST_RD_OE,
    ST_DONE
  } pps_state_e;

  // mode-select codes seen by the target
  localparam logic [1:0] MS_ADDR = 2'b00;
  localparam logic [1:0] MS_DATA = 2'b01;
  localparam logic [1:0] MS_CMD  = 2'b10;
  localparam logic [1:0] MS_IDLE = 2'b11;

  function automatic logic [PPS_DW-1:0] pps_cmd(pps_op_e op);
    case (op)
      OP_ERASE: pps_cmd = PPS_DW'(8'h80);
      OP_FUSE:  pps_cmd = PPS_DW'(8'h40);
      OP_LOCK:  pps_cmd = PPS_DW'(8'h20);
      default:  pps_cmd = PPS_DW'(8'h04);
    endcase
  endfunction

  function automatic logic pps_has_data(pps_op_e op);
    pps_has_data = (op == OP_FUSE) || (op == OP_LOCK);
  endfunction

  function automatic int pps_max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    pps_max3 = (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pps_rst_sync.sv
module pps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pps_timer.sv
module pps_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - TW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
#(
  parameter int TW         = 8,
  parameter int PULSE_CYC  = 2,
  parameter int SETTLE_CYC = 3,
  parameter int WAIT_CYC   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  pps_op_e           op_in,
  input  logic [PPS_DW-1:0] wdata_in,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  output pps_state_e        st_q,
  output pps_state_e        st_d,
  output pps_op_e           op_d,
  output logic [PPS_DW-1:0] wd_d
);
  localparam logic [TW-1:0] LD_PULSE  = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] LD_SETTLE = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] LD_WAIT   = TW'(WAIT_CYC - 1);

  pps_op_e           op_q;
  logic [PPS_DW-1:0] wd_q;
  logic              accept;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        accept   = 1'b1;
        st_d     = ST_CMD_SET;
        tmr_load = 1'b1;
        tmr_val  = LD_SETTLE;
      end
      ST_CMD_SET: if (tmr_zero) begin
        st_d     = ST_CMD_STB;
        tmr_load = 1'b1;
        tmr_val  = LD_PULSE;
      end
      ST_CMD_STB: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (op_q == OP_READ) begin
          st_d    = ST_RD_SET;
          tmr_val = LD_SETTLE;
        end else if (pps_has_data(op_q)) begin
          st_d    = ST_DAT_SET;
          tmr_val = LD_SETTLE;
        end else begin
          st_d    = ST_WE;
          tmr_val = LD_PULSE;
        end
      end
      ST_DAT_SET: if (tmr_zero) begin
        st_d     = ST_DAT_STB;
        tmr_load = 1'b1;
        tmr_val  = LD_PULSE;
      end
      ST_DAT_STB: if (tmr_zero) begin
        st_d     = ST_WE;
        tmr_load = 1'b1;
        tmr_val  = LD_PULSE;
      end
      ST_WE: if (tmr_zero) begin
        st_d     = ST_WAIT;
        tmr_load = 1'b1;
        tmr_val  = LD_WAIT;
      end
      ST_WAIT: if (tmr_zero) begin
        st_d     = ST_DONE;
        tmr_load = 1'b1;
      end
      ST_RD_SET: if (tmr_zero) begin
        st_d     = ST_RD_OE;
        tmr_load = 1'b1;
        tmr_val  = LD_SETTLE;
      end
      ST_RD_OE: if (tmr_zero) begin
        st_d     = ST_DONE;
        tmr_load = 1'b1;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    op_d = accept ? op_in    : op_q;
    wd_d = accept ? wdata_in : wd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      op_q <= OP_ERASE;
      wd_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        op_q <= op_d;
        wd_q <= wd_d;
      end
    end
  end
endmodule

// File: rtl/pps_pins.sv
module pps_pins
  import pps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pps_state_e        st_q,
  input  pps_state_e        st_d,
  input  pps_op_e           op_d,
  input  logic [PPS_DW-1:0] wd_d,
  input  logic [PPS_DW-1:0] bus_in,
  output logic [1:0]        msel,
  output logic              byte_sel,
  output logic              strobe,
  output logic              we_n,
  output logic              oe_n,
  output logic              bus_drv,
  output logic [PPS_DW-1:0] bus_out,
  output logic              done,
  output logic [PPS_DW-1:0] rdata
);
  logic [1:0]        msel_d;
  logic              strobe_d;
  logic              we_n_d;
  logic              oe_n_d;
  logic              drv_d;
  logic [PPS_DW-1:0] bus_d;
  logic              done_d;
  logic              cap_en;

  // decode the pins of the coming state so they leave flops
  always_comb begin
    msel_d   = MS_IDLE;
    strobe_d = 1'b0;
    we_n_d   = 1'b1;
    oe_n_d   = 1'b1;
    drv_d    = 1'b0;
    bus_d    = '0;
    done_d   = 1'b0;
    case (st_d)
      ST_CMD_SET, ST_CMD_STB: begin
        msel_d   = MS_CMD;
        drv_d    = 1'b1;
        bus_d    = pps_cmd(op_d);
        strobe_d = (st_d == ST_CMD_STB);
      end
      ST_DAT_SET, ST_DAT_STB: begin
        msel_d   = MS_DATA;
        drv_d    = 1'b1;
        bus_d    = wd_d;
        strobe_d = (st_d == ST_DAT_STB);
      end
      ST_WE:    we_n_d = 1'b0;
      ST_RD_OE: oe_n_d = 1'b0;
      ST_DONE:  done_d = 1'b1;
      default:  ;
    endcase
    cap_en = (st_q == ST_RD_OE) && (st_d == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msel     <= MS_IDLE;
      byte_sel <= 1'b1;
      strobe   <= 1'b0;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      bus_drv  <= 1'b0;
      bus_out  <= '0;
      done     <= 1'b0;
    end else begin
      msel     <= msel_d;
      byte_sel <= msel_d[1] & msel_d[0];
      strobe   <= strobe_d;
      we_n     <= we_n_d;
      oe_n     <= oe_n_d;
      bus_drv  <= drv_d;
      bus_out  <= bus_d;
      done     <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= bus_in;
  end
endmodule

// File: rtl/pps_seq.sv
module pps_seq
  import pps_pkg::*;
#(
  parameter int PULSE_CYC  = 8,
  parameter int SETTLE_CYC = 320,
  parameter int WAIT_CYC   = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [PPS_DW-1:0] wdata_i,
  output logic              done_o,
  output logic [PPS_DW-1:0] rdata_o,
  output logic [1:0]        msel_o,
  output logic              byte_sel_o,
  output logic              strobe_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic              bus_drv_o,
  output logic [PPS_DW-1:0] bus_o,
  input  logic [PPS_DW-1:0] bus_i
);
  localparam int TW = $clog2(pps_max3(PULSE_CYC, SETTLE_CYC, WAIT_CYC) + 1);

  logic              rst_sync_n;
  logic              tmr_load;
  logic [TW-1:0]     tmr_val;
  logic              tmr_zero;
  pps_state_e        st_q;
  pps_state_e        st_d;
  pps_op_e           op_d;
  logic [PPS_DW-1:0] wd_d;

  pps_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pps_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  pps_ctrl #(
    .TW         (TW),
    .PULSE_CYC  (PULSE_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .WAIT_CYC   (WAIT_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start_i),
    .op_in    (pps_op_e'(op_i)),
    .wdata_in (wdata_i),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .st_q     (st_q),
    .st_d     (st_d),
    .op_d     (op_d),
    .wd_d     (wd_d)
  );

  pps_pins u_pins (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .st_q     (st_q),
    .st_d     (st_d),
    .op_d     (op_d),
    .wd_d     (wd_d),
    .bus_in   (bus_i),
    .msel     (msel_o),
    .byte_sel (byte_sel_o),
    .strobe   (strobe_o),
    .we_n     (we_n_o),
    .oe_n     (oe_n_o),
    .bus_drv  (bus_drv_o),
    .bus_out  (bus_o),
    .done     (done_o),
    .rdata    (rdata_o)
  );
endmodule

// File: rtl/pps_seq_chk.sv
module pps_seq_chk #(
  parameter int SETTLE_CYC = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] msel,
  input logic       strobe,
  input logic       we_n,
  input logic       oe_n,
  input logic       bus_drv,
  input logic [7:0] bus,
  input logic       done
);
  logic [1:0]  msel_q;
  logic [31:0] stab;

  // cycles the select pair held its value before the current cycle, minus one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msel_q <= 2'b11;
      stab   <= '0;
    end else begin
      msel_q <= msel;
      if (msel != msel_q)              stab <= '0;
      else if (stab < 32'(SETTLE_CYC)) stab <= stab + 32'd1;
    end
  end

  a_r7_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  a_r4_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> (msel == msel_q) && (stab + 32'd1 >= 32'(SETTLE_CYC)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe)) |-> ($stable(msel) && $stable(bus)));

  a_r2_strobe_drives: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> bus_drv);

  a_r5_we_released: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!bus_drv && msel == 2'b11 && !strobe));

  a_r6_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!bus_drv && msel == 2'b11 && !strobe));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind pps_seq pps_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .msel    (msel_o),
  .strobe  (strobe_o),
  .we_n    (we_n_o),
  .oe_n    (oe_n_o),
  .bus_drv (bus_drv_o),
  .bus     (bus_o),
  .done    (done_o)
);

// File: tb/tb_pps_seq.sv
`timescale 1ns/1ps
module tb_pps_seq;
  localparam int PULSE  = 2;
  localparam int SETTLE = 3;
  localparam int WAITC  = 6;

  typedef struct packed {
    logic [1:0] msel;
    logic       stb;
    logic       we_n;
    logic       oe_n;
    logic       drv;
    logic [7:0] bus;
    logic       done;
    logic       rd_upd;
    logic [7:0] rd_val;
  } pin_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [1:0] op;
  logic [7:0] wdata;
  logic       done;
  logic [7:0] rdata;
  logic [1:0] msel;
  logic       bsel, strobe, we_n, oe_n, drv;
  logic [7:0] bus_o;
  logic [7:0] bus_i;
  logic [7:0] tgt;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit run_cmp = 0;
  bit cur_busy = 0;
  logic [7:0] exp_rd = 8'h00;
  pin_t q[$];

  always #5 clk = ~clk;

  assign bus_i = !oe_n ? tgt : 8'h00;

  pps_seq #(.PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE), .WAIT_CYC(WAITC)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .wdata_i(wdata),
    .done_o(done), .rdata_o(rdata), .msel_o(msel), .byte_sel_o(bsel),
    .strobe_o(strobe), .we_n_o(we_n), .oe_n_o(oe_n), .bus_drv_o(drv),
    .bus_o(bus_o), .bus_i(bus_i)
  );

  function automatic pin_t idle_pin();
    pin_t p;
    p = '0;
    p.msel = 2'b11; p.we_n = 1'b1; p.oe_n = 1'b1;
    return p;
  endfunction

  function automatic logic [7:0] code_of(logic [1:0] o);
    case (o)
      2'b00: return 8'h80;
      2'b01: return 8'h40;
      2'b10: return 8'h20;
      default: return 8'h04;
    endcase
  endfunction

  task automatic push_n(pin_t p, int n);
    for (int i = 0; i < n; i++) q.push_back(p);
  endtask

  // behavioural expectation of one whole operation
  task automatic model_op(logic [1:0] o, logic [7:0] wd);
    pin_t p;
    p = idle_pin(); p.msel = 2'b10; p.drv = 1'b1; p.bus = code_of(o);
    push_n(p, SETTLE);                          // R2 command setup
    p.stb = 1'b1; push_n(p, PULSE);             // R2 command strobe
    if (o == 2'b11) begin
      push_n(idle_pin(), SETTLE);               // R6 released bus
      p = idle_pin(); p.oe_n = 1'b0; push_n(p, SETTLE);
      p = idle_pin(); p.done = 1'b1; p.rd_upd = 1'b1; p.rd_val = tgt;
      q.push_back(p);
    end else begin
      if (o != 2'b00) begin                     // R11: erase skips this
        p = idle_pin(); p.msel = 2'b01; p.drv = 1'b1; p.bus = wd;
        push_n(p, SETTLE);                      // R3
        p.stb = 1'b1; push_n(p, PULSE);
      end
      p = idle_pin(); p.we_n = 1'b0; push_n(p, PULSE);  // R5
      push_n(idle_pin(), WAITC);
      p = idle_pin(); p.done = 1'b1; q.push_back(p);
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // reference: accepts a start only when the cycle now ending is idle (R9)
  always @(posedge clk) begin
    cyc++;
    if (run_cmp && start === 1'b1 && !cur_busy) model_op(op, wdata);
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog cycle %0d actual running expected finished", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    pin_t e;
    if (run_cmp) begin
      if (q.size() != 0) begin e = q.pop_front(); cur_busy = 1'b1; end
      else begin e = idle_pin(); cur_busy = 1'b0; end
      if (e.rd_upd) exp_rd = e.rd_val;
      chk("R2/R3 msel", 32'(msel), 32'(e.msel));
      chk("R4 strobe", 32'(strobe), 32'(e.stb));
      chk("R5 we_n", 32'(we_n), 32'(e.we_n));
      chk("R6 oe_n", 32'(oe_n), 32'(e.oe_n));
      chk("R2 bus_drv", 32'(drv), 32'(e.drv));
      chk("R2 bus", 32'(bus_o), 32'(e.bus));
      chk("R10 done", 32'(done), 32'(e.done));
      chk("R8 byte_sel", 32'(bsel), 32'(e.msel[1] & e.msel[0]));
      chk("R7 enables", 32'(!oe_n && !we_n), 32'd0);
      chk("R6/R10 rdata", 32'(rdata), 32'(exp_rd));
    end
  end

  task automatic issue(logic [1:0] o, logic [7:0] wd);
    @(negedge clk); #1;
    start = 1'b1; op = o; wdata = wd;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_idle();
    @(posedge clk); #1;
    while (q.size() != 0) begin @(posedge clk); #1; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 2'b00; wdata = 8'h00; tgt = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state at the pins
    chk("R1 msel", 32'(msel), 32'd3);
    chk("R1 we_n/oe_n", 32'({we_n, oe_n}), 32'd3);
    chk("R1 strobe/drv/done", 32'({strobe, drv, done}), 32'd0);
    chk("R1 bus/rdata", 32'({bus_o, rdata}), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_cmp = 1'b1;
    repeat (3) @(negedge clk);

    issue(2'b00, 8'hFF); wait_idle();           // R11 erase
    issue(2'b01, 8'hA5); wait_idle();           // R3 fuse write
    issue(2'b10, 8'h3C); wait_idle();           // R3 lock write
    tgt = 8'h5A; issue(2'b11, 8'h00); wait_idle();   // R6 read
    tgt = 8'hC3; issue(2'b11, 8'h11); wait_idle();   // R6 second read
    tgt = 8'h00;
    issue(2'b01, 8'h0F); wait_idle();           // R10 rdata holds C3

    // R9: start pulses during a running write are ignored
    issue(2'b10, 8'h99);
    repeat (4) @(negedge clk);
    #1; start = 1'b1; op = 2'b00; wdata = 8'h77;
    @(negedge clk); #1; start = 1'b0;
    repeat (9) @(negedge clk);
    #1; start = 1'b1; op = 2'b11;
    @(negedge clk); #1; start = 1'b0;
    wait_idle();

    // R9: start held high is refused in the done cycle, taken when idle
    tgt = 8'h96;
    @(negedge clk); #1; start = 1'b1; op = 2'b11; wdata = 8'h00;
    repeat (2 * (2 * SETTLE + PULSE + SETTLE + 1) + 4) @(negedge clk);
    #1; start = 1'b0;
    wait_idle();

    run_cmp = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule